// File: doc/BRIEF.md
# Receive Queue Port with Explicit Advance

This block is a memory-mapped character port. A line receiver pushes bytes into an eight-entry queue, and software reads them over a simple synchronous register bus. Looking at the receive data location shows the oldest byte and never removes it. Software frees that byte with a write to a separate advance location. As a result, a retried bus read, a speculative read, or the destination read of a read-modify-write store cannot lose input.

Outgoing bytes go through their own write-only transmit location. A transmit store therefore never shares an address with anything a read would disturb. Each transmit write is presented to the line side as a one-cycle strobe with the byte. A status location reports empty, full, a sticky overrun flag and the number of bytes held. The overrun flag is set when the receiver pushes into a full queue, and software clears it by writing 1 to it.

Top module: `rxq_port`

## Requirements
- R1: After reset the queue is empty, the status read returns 0x01 (empty set, count 0, no overrun), and `tx_strobe` is low.
- R2: A read of address 0 (receive data) returns the oldest held byte and changes no state. Repeated reads return the same byte until an advance write.
- R3: A write of any data to address 2 (advance) removes the oldest byte. Bytes are then presented in the order they were pushed.
- R4: With the queue empty, a receive data read returns 0x00 and an advance write leaves the queue empty.
- R5: A read of address 3 (status) returns bit 0 = empty, bit 1 = full, bit 2 = overrun, bits 7:4 = byte count (0 to 8) and bit 3 = 0.
- R6: A push while the queue holds 8 bytes, with no advance in that cycle, is dropped and sets the overrun flag. The held bytes and their order do not change.
- R7: A write to address 3 with bit 2 set clears the overrun flag, and a write with bit 2 clear leaves it. If a drop happens in the same cycle as a clear, the flag ends up set.
- R8: A write to address 1 (transmit) raises `tx_strobe` for exactly the next cycle, with `tx_byte` equal to the written byte, and leaves the queue untouched. A write to address 0 is ignored.
- R9: A push and an advance in the same cycle on a non-empty queue leave the count unchanged and keep the order. This holds when the queue is full, and in that case the push is accepted.
- R10: Reads of address 1 and address 2 return 0x00 and change no state. `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Register address: 0 receive data, 1 transmit, 2 advance, 3 status |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no read is in progress |
| rx_push | input | 1 | Line receiver offers a byte this cycle |
| rx_byte | input | 8 | Received byte |
| tx_strobe | output | 1 | One-cycle transmit request |
| tx_byte | output | 8 | Byte to transmit, valid with `tx_strobe` |

## Verification
The hardest cases to reach from the ports all happen at the full boundary in a single cycle: a push that meets an advance while 8 bytes are held, and a drop that meets an overrun-clear write. The stimulus alternates long phases of heavy and light push traffic. This keeps the queue pinned at full for stretches while random advance, clear, read and transmit operations land on it. Directed steps cover each collision once beforehand, and then drain the queue to confirm that order survived.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_RXDATA  = 2'd0;
  localparam logic [ADDR_W-1:0] A_TXDATA  = 2'd1;
  localparam logic [ADDR_W-1:0] A_ADVANCE = 2'd2;
  localparam logic [ADDR_W-1:0] A_STATUS  = 2'd3;

  localparam int unsigned ST_EMPTY   = 0;
  localparam int unsigned ST_FULL    = 1;
  localparam int unsigned ST_OVR     = 2;
  localparam int unsigned ST_CNT_LSB = 4;
  localparam int unsigned ST_CNT_W   = 4;

  typedef struct packed {
    logic pop_req;
    logic tx_load;
    logic ovr_clear;
  } rxq_cmd_t;
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DATA_W-1:0]            push_data,
  input  logic                         pop_req,
  output logic [DATA_W-1:0]            head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full,
  output logic                         dropped
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] mem [DEPTH];
  logic              pop, accept;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign pop     = pop_req && !empty;
  assign accept  = push && (!full || pop);
  assign dropped = push && !accept;
  assign count   = cnt_q;
  assign head    = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q + CNT_W'(accept) - CNT_W'(pop);
    if (accept) wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + PTR_W'(1);
    if (pop)    rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH-1)) ? '0 : rd_ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = accept && (wr_ptr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (slot_we) mem[i] <= push_data;
    end
  end
endmodule

// File: rtl/rxq_regmap.sv
module rxq_regmap #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [rxq_pkg::ADDR_W-1:0]      bus_addr,
  input  logic                            bus_rd,
  input  logic                            bus_wr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata,
  input  logic [DATA_W-1:0]               head,
  input  logic [$clog2(DEPTH+1)-1:0]      count,
  input  logic                            empty,
  input  logic                            full,
  input  logic                            dropped,
  output logic                            pop_req,
  output logic                            overrun,
  output logic                            tx_strobe,
  output logic [DATA_W-1:0]               tx_byte
);
  import rxq_pkg::*;

  rxq_cmd_t          cmd;
  logic              ovr_q, ovr_d;
  logic              stb_q;
  logic [DATA_W-1:0] txb_q;

  always_comb begin
    cmd           = '0;
    cmd.pop_req   = bus_wr && (bus_addr == A_ADVANCE);
    cmd.tx_load   = bus_wr && (bus_addr == A_TXDATA);
    cmd.ovr_clear = bus_wr && (bus_addr == A_STATUS) && bus_wdata[ST_OVR];
  end

  always_comb begin
    ovr_d = ovr_q;
    if (cmd.ovr_clear) ovr_d = 1'b0;
    if (dropped)       ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      stb_q <= 1'b0;
      txb_q <= '0;
    end else begin
      ovr_q <= ovr_d;
      stb_q <= cmd.tx_load;
      if (cmd.tx_load) txb_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_RXDATA: bus_rdata = empty ? '0 : head;
        A_STATUS: begin
          bus_rdata[ST_EMPTY] = empty;
          bus_rdata[ST_FULL]  = full;
          bus_rdata[ST_OVR]   = ovr_q;
          bus_rdata[ST_CNT_LSB +: ST_CNT_W] = ST_CNT_W'(count);
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pop_req   = cmd.pop_req;
  assign overrun   = ovr_q;
  assign tx_strobe = stb_q;
  assign tx_byte   = txb_q;
endmodule

// File: rtl/rxq_port.sv
module rxq_port #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [rxq_pkg::ADDR_W-1:0] bus_addr,
  input  logic                       bus_rd,
  input  logic                       bus_wr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic                       rx_push,
  input  logic [DATA_W-1:0]          rx_byte,
  output logic                       tx_strobe,
  output logic [DATA_W-1:0]          tx_byte
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [DATA_W-1:0] fifo_head;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              fifo_empty, fifo_full, fifo_drop, pop_req, ovr_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  rxq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (rx_push),
    .push_data (rx_byte),
    .pop_req   (pop_req),
    .head      (fifo_head),
    .count     (fifo_cnt),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .dropped   (fifo_drop)
  );

  rxq_regmap #(.DEPTH(DEPTH), .DATA_W(DATA_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .head      (fifo_head),
    .count     (fifo_cnt),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .dropped   (fifo_drop),
    .pop_req   (pop_req),
    .overrun   (ovr_flag),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte)
  );
endmodule

// File: rtl/rxq_port_chk.sv
module rxq_port_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [rxq_pkg::ADDR_W-1:0] bus_addr,
  input logic                       bus_rd,
  input logic                       bus_wr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic                       rx_push,
  input logic                       tx_strobe,
  input logic [DATA_W-1:0]          tx_byte,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       empty,
  input logic                       full,
  input logic                       overrun,
  input logic [DATA_W-1:0]          head
);
  import rxq_pkg::*;
  logic adv_wr, tx_wr, clr_wr;
  assign adv_wr = bus_wr && (bus_addr == A_ADVANCE);
  assign tx_wr  = bus_wr && (bus_addr == A_TXDATA);
  assign clr_wr = bus_wr && (bus_addr == A_STATUS) && bus_wdata[ST_OVR];

  // R2
  rx_peek_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !rx_push && !empty && bus_addr == A_RXDATA)
    |=> (count == $past(count) && head == $past(head)));
  // R3
  advance_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_wr && !empty && !rx_push) |=> (count == $past(count) - 1'b1));
  // R4
  empty_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_wr && empty && !rx_push) |=> empty);
  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && full && !adv_wr) |=> (overrun && full));
  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr_wr) |=> overrun);
  // R8
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> (tx_strobe && tx_byte == $past(bus_wdata)));
  // R8
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_wr |=> !tx_strobe);
  // R9
  push_pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && adv_wr && !empty) |=> (count == $past(count)));
endmodule

bind rxq_port rxq_port_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .rx_push   (rx_push),
  .tx_strobe (tx_strobe),
  .tx_byte   (tx_byte),
  .count     (fifo_cnt),
  .empty     (fifo_empty),
  .full      (fifo_full),
  .overrun   (ovr_flag),
  .head      (fifo_head)
);

// File: tb/rxq_port_tb_top.sv
`timescale 1ns/1ps
module rxq_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_rd, bus_wr, rx_push;
  logic [7:0] bus_wdata, rx_byte, bus_rdata, tx_byte;
  logic       tx_strobe;

  always #2 clk = ~clk;

  rxq_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_push(rx_push), .rx_byte(rx_byte), .tx_strobe(tx_strobe), .tx_byte(tx_byte)
  );

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;
  logic [7:0] mq[$];
  bit   m_ovr = 1'b0;
  bit   m_stb = 1'b0;
  logic [7:0] m_txb = 8'h00;

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    logic [7:0] v = 8'h00;
    int n = mq.size();
    if (a == 2'd0) v = (n > 0) ? mq[0] : 8'h00;
    else if (a == 2'd3) v = {4'(n), 1'b0, m_ovr, (n == 8), (n == 0)};
    return v;
  endfunction

  task automatic step(input logic [1:0] a, input bit rd, input bit wr, input logic [7:0] wd,
                      input bit psh, input logic [7:0] pb, input string req);
    logic [7:0] exp;
    bit pop, acc;
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; rx_push = psh; rx_byte = pb;
    #1;
    exp = rd ? exp_read(a) : 8'h00;
    check(bus_rdata == exp, req, bus_rdata, exp);
    check(tx_strobe == m_stb, "R8", {7'b0, tx_strobe}, {7'b0, m_stb});
    if (m_stb) check(tx_byte == m_txb, "R8", tx_byte, m_txb);
    @(posedge clk);
    m_stb = wr && (a == 2'd1);
    if (m_stb) m_txb = wd;
    pop = wr && (a == 2'd2) && (mq.size() > 0);
    acc = psh && ((mq.size() < 8) || pop);
    if (pop) void'(mq.pop_front());
    if (acc) mq.push_back(pb);
    if (wr && a == 2'd3 && wd[2]) m_ovr = 1'b0;
    if (psh && !acc) m_ovr = 1'b1;
  endtask

  initial begin
    #(100000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_addr = 2'd0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_wdata = 8'h00; rx_push = 1'b0; rx_byte = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(2'd0, 0, 0, 8'h00, 0, 8'h00, "R10");
    // R1 reset status
    step(2'd3, 1, 0, 8'h00, 0, 8'h00, "R1");
    check(bus_rdata == 8'h01, "R1", bus_rdata, 8'h01);
    // R4 empty read and advance
    step(2'd0, 1, 0, 8'h00, 0, 8'h00, "R4");
    step(2'd2, 0, 1, 8'h5A, 0, 8'h00, "R4");
    step(2'd3, 1, 0, 8'h00, 0, 8'h00, "R4");
    // fill to full
    for (int i = 0; i < 8; i++) step(2'd0, 0, 0, 8'h00, 1, 8'hA0 + 8'(i), "R3");
    step(2'd3, 1, 0, 8'h00, 0, 8'h00, "R5");
    check(bus_rdata == 8'h82, "R5", bus_rdata, 8'h82);
    // R2 retried reads
    for (int i = 0; i < 3; i++) step(2'd0, 1, 0, 8'h00, 0, 8'h00, "R2");
    // R8 / R10 ignored accesses
    step(2'd0, 0, 1, 8'hEE, 0, 8'h00, "R8");
    step(2'd1, 1, 0, 8'h00, 0, 8'h00, "R10");
    step(2'd2, 1, 0, 8'h00, 0, 8'h00, "R10");
    step(2'd0, 1, 0, 8'h00, 0, 8'h00, "R10");
    // R6 overrun
    step(2'd0, 0, 0, 8'h00, 1, 8'h55, "R6");
    step(2'd3, 1, 0, 8'h00, 0, 8'h00, "R6");
    check(bus_rdata == 8'h86, "R6", bus_rdata, 8'h86);
    // R9 push + advance at full
    step(2'd2, 0, 1, 8'h00, 1, 8'h66, "R9");
    step(2'd0, 1, 0, 8'h00, 0, 8'h00, "R9");
    check(bus_rdata == 8'hA1, "R9", bus_rdata, 8'hA1);
    // R7 clear: set wins over clear, bit2=0 keeps, bit2=1 clears
    step(2'd3, 0, 1, 8'h04, 1, 8'h77, "R7");
    step(2'd3, 0, 1, 8'hFB, 0, 8'h00, "R7");
    step(2'd3, 1, 0, 8'h00, 0, 8'h00, "R7");
    step(2'd3, 0, 1, 8'h04, 0, 8'h00, "R7");
    step(2'd3, 1, 0, 8'h00, 0, 8'h00, "R7");
    // R8 transmit
    step(2'd1, 0, 1, 8'h3C, 0, 8'h00, "R8");
    step(2'd1, 0, 1, 8'hC3, 0, 8'h00, "R8");
    step(2'd3, 1, 0, 8'h00, 0, 8'h00, "R8");
    // R3 drain in order
    for (int i = 0; i < 9; i++) begin
      step(2'd0, 1, 0, 8'h00, 0, 8'h00, "R3");
      step(2'd2, 0, 1, 8'h00, 0, 8'h00, "R3");
    end
    step(2'd3, 1, 0, 8'h00, 0, 8'h00, "R4");
    // random phases
    for (int ph = 0; ph < 20; ph++) begin
      int prate = (ph % 2 == 0) ? 75 : 15;
      for (int k = 0; k < 200; k++) begin
        int op = $urandom_range(0, 7);
        bit psh = ($urandom_range(0, 99) < prate);
        logic [7:0] pb = 8'($urandom);
        logic [7:0] wd = 8'($urandom);
        case (op)
          0: step(2'd0, 1, 0, wd, psh, pb, "R2");
          1: step(2'd3, 1, 0, wd, psh, pb, "R5");
          2: step(2'd2, 0, 1, wd, psh, pb, "R9");
          3: step(2'd1, 0, 1, wd, psh, pb, "R8");
          4: step(2'd3, 0, 1, wd, psh, pb, "R7");
          5: step(2'($urandom_range(1, 2)), 1, 0, wd, psh, pb, "R10");
          6: step(2'd0, 0, 1, wd, psh, pb, "R8");
          default: step(2'd0, 0, 0, wd, psh, pb, "R6");
        endcase
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule